// File: doc/BRIEF.md
# Timer Compare Period Trigger

This block pairs a 16-bit up-counting timer with a 16-bit compare register. The timer advances one step on every system clock cycle in which the tick input is high. When the control register selects the period-trigger mode and the count equals the compare value, the block raises a sticky compare flag. It can also send a one-cycle conversion-start strobe to an ADC. On the next tick it then returns the timer to zero. The compare register therefore sets the timer period: with compare value N, the count runs from 0 up to N, so one period lasts N+1 ticks.

Software programs the compare value one byte at a time, and sets the mode and the ADC-start option, through a byte-wide write port. The zeroing only takes effect on a later tick, so the match leaves a reset pending. That pending reset is dropped if software rewrites either compare byte first, or leaves the trigger mode first. The timer then counts on past the old compare value. The zeroing never counts as an overflow. The overflow flag is raised only when ticking wraps the count from all ones to zero. The pin-control output is never driven.

Top module: `timer_period_trigger`

## Requirements
- R1: Compare events occur only while control bits [3:0] hold 4'b1011. With any other value, a count equal to the compare value sets no flag, sends no strobe and leaves the count untouched.
- R2: A match sets `cmp_flag`, which is visible one clock after the cycle in which the count first equals the compare value. The flag stays set until `cmp_flag_clr` is high. A clear that falls in the same cycle as a new match leaves the flag set.
- R3: `adc_start` is high for exactly one clock, in the cycle after the match cycle. It pulses only when control bit 4 is set and the ADC option parameter is enabled.
- R4: The count goes up by one on each clock edge where `tick` is high, and holds its value otherwise.
- R5: After a match, the first tick in or after the match cycle loads the count with 0 instead of N+1. A compare value N therefore gives a period of N+1 ticks.
- R6: Loading zero after a match never sets `ovf_flag`. `ovf_flag` is set only when a tick moves the count from 16'hFFFF to 0. It stays set until `ovf_flag_clr` is high.
- R7: A write to either compare byte while a reset is pending cancels that reset. The next tick then gives the old compare value plus one.
- R8: Write address 0 holds the compare low byte and address 1 holds the compare high byte. Address 2 is the control register: mode in bits [3:0], ADC start enable in bit 4.
- R9: `cmp_pin` stays 0 in every mode and on every event.
- R10: Leaving the trigger mode while a reset is pending cancels that reset, so the next tick increments the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare low, 1 compare high, 2 control |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Timer advance enable |
| cmp_flag_clr | input | 1 | Clear for the compare flag |
| ovf_flag_clr | input | 1 | Clear for the overflow flag |
| count | output | 16 | Current timer value |
| cmp_flag | output | 1 | Sticky compare-event flag |
| ovf_flag | output | 1 | Sticky timer-wrap flag |
| adc_start | output | 1 | One-cycle conversion-start strobe |
| cmp_pin | output | 1 | Pin-control output, held inactive |

## Verification
Two pairs of actions can fall in the same cycle. In the first, a match and a software flag clear coincide. The bench provokes this by driving `cmp_flag_clr` in the exact cycle the count first shows the compare value, and it expects the flag to read 1 afterwards. In the second, the pending reset and the natural wrap coincide: the compare value is set to 16'hFFFF, so the tick that would wrap the count is the same tick that zeroes it. The bench expects a count of 0 with `ovf_flag` still 0, and compares this against a separate run where an ordinary wrap does raise the flag.

// File: rtl/tpt_pkg.sv
package tpt_pkg;
  // selects of the byte-wide write port
  localparam int unsigned SEL_CMP_LO = 0;
  localparam int unsigned SEL_CMP_HI = 1;
  localparam int unsigned SEL_CTRL   = 2;
  // control byte layout
  localparam int unsigned CTRL_ADC_BIT = 4;
  // mode code for period-trigger behaviour
  localparam logic [3:0] MODE_PERIOD_TRIG = 4'b1011;
endpackage

// File: rtl/tpt_regs.sv
module tpt_regs #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [MODE_W-1:0] mode,
  output logic              adc_on,
  output logic              cmp_wr
);
  import tpt_pkg::*;
  localparam int unsigned NLANE = CNT_W / BYTE_W;

  logic [NLANE-1:0] lane_wr;

  // one register per compare byte lane
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_wr[g] = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)          cmp_val[g*BYTE_W +: BYTE_W] <= '0;
      else if (lane_wr[g]) cmp_val[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  // named event: any compare byte written this cycle
  assign cmp_wr = |lane_wr;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(SEL_CTRL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= '0;
      adc_on <= 1'b0;
    end else if (ctrl_wr) begin
      mode   <= wr_data[MODE_W-1:0];
      adc_on <= wr_data[CTRL_ADC_BIT];
    end
  end

  // R8: a compare write lands in the addressed byte only
  assert_lo_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr[0] |=> cmp_val[BYTE_W-1:0] == $past(wr_data));
  assert_ctrl_keeps_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr) |=> $stable(cmp_val));
endmodule

// File: rtl/tpt_timer.sv
module tpt_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reset_req,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  function automatic logic [CNT_W-1:0] f_next(input logic [CNT_W-1:0] c,
                                              input logic t, input logic z);
    if (!t)     return c;
    else if (z) return '0;
    else        return c + 1'b1;
  endfunction

  function automatic logic f_wraps(input logic [CNT_W-1:0] c,
                                   input logic t, input logic z);
    return t && !z && (c == ALL_ONES);
  endfunction

  assign wrap_evt = f_wraps(count, tick, reset_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      count    <= f_next(count, tick, reset_req);
      ovf_flag <= wrap_evt | (ovf_flag & ~ovf_clr);
    end
  end

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> count == $past(count));
  assert_reset_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reset_req) |=> count == '0);
  assert_reset_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reset_req && !ovf_flag) |=> !ovf_flag);
  assert_ovf_only_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(count) == ALL_ONES) && $past(tick));
endmodule

// File: rtl/tpt_event.sv
module tpt_event #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MODE_W    = 4,
  parameter logic [MODE_W-1:0] TRIG_MODE = 4'b1011,
  parameter bit          HAS_ADC   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic [MODE_W-1:0] mode,
  input  logic              adc_on,
  input  logic              cmp_wr,
  input  logic              tick,
  input  logic              cmp_clr,
  output logic              match_evt,
  output logic              reset_req,
  output logic              cmp_flag,
  output logic              adc_start
);
  logic mode_ok;
  logic pend_q;

  function automatic logic f_hit(input logic [CNT_W-1:0] c,
                                 input logic [CNT_W-1:0] v);
    return c == v;
  endfunction

  assign mode_ok   = (mode == TRIG_MODE);
  // a held count fires once; the pending bit suppresses repeats
  assign match_evt = mode_ok && f_hit(count, cmp_val) && !pend_q;
  // the zeroing waits for a tick and is dropped by a compare write
  assign reset_req = mode_ok && !cmp_wr && (pend_q || match_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (!mode_ok || cmp_wr || tick) pend_q <= 1'b0;
      else                            pend_q <= pend_q | match_evt;
      cmp_flag <= match_evt | (cmp_flag & ~cmp_clr);
    end
  end

  if (HAS_ADC) begin : g_adc
    always_ff @(posedge clk) begin
      if (!rst_n) adc_start <= 1'b0;
      else        adc_start <= match_evt & adc_on;
    end
  end else begin : g_no_adc
    assign adc_start = 1'b0;
  end

  assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> !match_evt && !reset_req);
  assert_flag_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);
  assert_adc_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(match_evt) && $past(adc_on));
  assert_write_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend_q);
  assert_mode_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> !pend_q);
endmodule

// File: rtl/timer_period_trigger.sv
module timer_period_trigger #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MODE_W  = 4,
  parameter int unsigned ADDR_W  = 2,
  parameter bit          HAS_ADC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tick,
  input  logic              cmp_flag_clr,
  input  logic              ovf_flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              cmp_flag,
  output logic              ovf_flag,
  output logic              adc_start,
  output logic              cmp_pin
);
  import tpt_pkg::*;

  logic [CNT_W-1:0]  cmp_val;
  logic [MODE_W-1:0] mode;
  logic              adc_on;
  logic              cmp_wr;
  logic              match_evt;
  logic              reset_req;
  logic              wrap_evt;

  tpt_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .MODE_W(MODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_val(cmp_val), .mode(mode), .adc_on(adc_on), .cmp_wr(cmp_wr)
  );

  tpt_event #(.CNT_W(CNT_W), .MODE_W(MODE_W), .TRIG_MODE(MODE_PERIOD_TRIG[MODE_W-1:0]),
              .HAS_ADC(HAS_ADC)) u_event (
    .clk(clk), .rst_n(rst_n), .count(count), .cmp_val(cmp_val), .mode(mode),
    .adc_on(adc_on), .cmp_wr(cmp_wr), .tick(tick), .cmp_clr(cmp_flag_clr),
    .match_evt(match_evt), .reset_req(reset_req), .cmp_flag(cmp_flag),
    .adc_start(adc_start)
  );

  tpt_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reset_req(reset_req),
    .ovf_clr(ovf_flag_clr), .count(count), .ovf_flag(ovf_flag), .wrap_evt(wrap_evt)
  );

  // R9: this mode never takes the pin
  assign cmp_pin = 1'b0;

  assert_wrap_not_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> !reset_req);
endmodule

// File: tb/test_timer_period_trigger.sv
module test_timer_period_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic        cmp_flag_clr = 1'b0;
  logic        ovf_flag_clr = 1'b0;
  logic [15:0] count;
  logic        cmp_flag, ovf_flag, adc_start, cmp_pin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  timer_period_trigger i_timer_period_trigger (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .cmp_flag_clr(cmp_flag_clr), .ovf_flag_clr(ovf_flag_clr),
    .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
    .adc_start(adc_start), .cmp_pin(cmp_pin)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic clr_cmp();
    cmp_flag_clr = 1'b1; step(); cmp_flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4", "count after reset", count, 0);
    chk("R2", "cmp_flag after reset", cmp_flag, 0);
    chk("R6", "ovf_flag after reset", ovf_flag, 0);
    chk("R3", "adc_start after reset", adc_start, 0);
    chk("R9", "cmp_pin after reset", cmp_pin, 0);
  endtask

  task automatic t_period();
    wr(2'd0, 8'h05); wr(2'd1, 8'h00); wr(2'd2, 8'h1B);
    ticks(0);
    chk("R4", "count idle while tick low", count, 0);
    tick = 1'b1;
    repeat (5) step();
    chk("R4", "count after 5 ticks", count, 5);
    chk("R2", "flag before match cycle ends", cmp_flag, 0);
    step();
    chk("R5", "count zeroed after match", count, 0);
    chk("R2", "flag set after match", cmp_flag, 1);
    chk("R3", "adc strobe after match", adc_start, 1);
    chk("R9", "pin after match", cmp_pin, 0);
    step();
    tick = 1'b0;
    chk("R5", "count restarts", count, 1);
    chk("R3", "adc strobe one cycle", adc_start, 0);
  endtask

  task automatic t_pending_hold();
    clr_cmp();
    chk("R2", "flag cleared", cmp_flag, 0);
    ticks(4);
    chk("R4", "count at compare", count, 5);
    step();
    chk("R2", "flag while held", cmp_flag, 1);
    chk("R3", "adc strobe while held", adc_start, 1);
    chk("R5", "no reset without tick", count, 5);
    step();
    chk("R3", "strobe gone in held match", adc_start, 0);
    chk("R4", "count held", count, 5);
    ticks(1);
    chk("R5", "pending reset on tick", count, 0);
  endtask

  task automatic t_cancel_write();
    ticks(5);
    step();
    wr(2'd0, 8'h09);
    ticks(1);
    chk("R7", "write cancels reset", count, 6);
    ticks(4);
    chk("R7", "new period end", count, 0);
  endtask

  task automatic t_clear_collide();
    clr_cmp();
    ticks(9);
    chk("R4", "count at 9", count, 9);
    cmp_flag_clr = 1'b1;
    step();
    chk("R2", "match beats clear", cmp_flag, 1);
    step();
    cmp_flag_clr = 1'b0;
    chk("R2", "later clear works", cmp_flag, 0);
    ticks(1);
    chk("R5", "reset after collision", count, 0);
  endtask

  task automatic t_no_adc();
    int seen = 0;
    wr(2'd2, 8'h0B);
    clr_cmp();
    tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      if (adc_start) seen++;
    end
    tick = 1'b0;
    chk("R3", "no strobe with adc off", seen, 0);
    chk("R5", "period with adc off", count, 0);
    chk("R2", "flag with adc off", cmp_flag, 1);
  endtask

  task automatic t_other_mode();
    wr(2'd2, 8'h0A);
    clr_cmp();
    ticks(10);
    chk("R1", "count passes compare", count, 10);
    chk("R1", "no flag in other mode", cmp_flag, 0);
  endtask

  task automatic t_wrap();
    tick = 1'b1;
    while (count != 16'hFFFF) step();
    chk("R6", "no ovf before wrap", ovf_flag, 0);
    step();
    tick = 1'b0;
    chk("R6", "wrap count", count, 0);
    chk("R6", "ovf on wrap", ovf_flag, 1);
    ovf_flag_clr = 1'b1; step(); ovf_flag_clr = 1'b0;
    chk("R6", "ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_reset_at_top();
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'h1B);
    clr_cmp();
    tick = 1'b1;
    while (count != 16'hFFFF) step();
    chk("R8", "no early match via high byte", cmp_flag, 0);
    step();
    tick = 1'b0;
    chk("R5", "reset at top", count, 0);
    chk("R6", "reset sets no ovf", ovf_flag, 0);
    chk("R2", "flag at top", cmp_flag, 1);
    chk("R9", "pin at top", cmp_pin, 0);
  endtask

  task automatic t_mode_drop();
    wr(2'd0, 8'h03); wr(2'd1, 8'h00);
    ticks(3);
    step();
    wr(2'd2, 8'h0A);
    ticks(1);
    chk("R10", "mode exit cancels reset", count, 4);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_period();
    t_pending_hold();
    t_cancel_write();
    t_clear_collide();
    t_no_adc();
    t_other_mode();
    t_wrap();
    t_reset_at_top();
    t_mode_drop();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule